// File: doc/BRIEF.md
# Coherent Read Snapshot Register Group

This block presents a group of hardware status registers to software through a 32-bit read port. Some registers are wider than the port, and some must be seen together as one consistent set. To keep those views consistent, each buffered register has shadow storage. A trigger event copies the live value into the shadow, and software reads return the shadow rather than the live value.

The group holds six registers:
- **Wide counter.** A 64-bit free-running counter that advances every clock. A read of its low word is its own trigger. That read returns the live low word and, on the same edge, copies every upper word into shadow storage. A later read of the upper word therefore returns the upper half of the same sample, even if a carry has crossed the word boundary in the meantime.
- **Group registers.** Two 32-bit status words are captured when software reads a third, live 32-bit status word.
- **Externally triggered registers.** Two more 32-bit words are captured on every clock in which an external trigger sits at its active level. The active level is a parameter.

Reads are single-cycle requests: a strobe with a word address. Data and acknowledge come back one clock later. A strobe output per register marks the cycle in which that register's fields are sampled.

Top module: `snap_rdbuf`

## Requirements
- R1: After reset, rd_ack and rd_data are 0, the wide counter holds CNT_RST, and every shadowed word reads back as 0 until it is first triggered.
- R2: A read strobe in cycle t gives rd_ack=1 together with its rd_data in cycle t+1. Without a strobe, rd_ack is 0 in the next cycle.
- R3: The counter advances by one every clock after reset. A read of word address 0 returns the counter's low 32 bits as they stood in the strobe cycle.
- R4: A read of word address 1 returns bits 63:32 of the counter as sampled at the most recent address-0 read. This holds even when a carry into bit 32 has happened since that read. Reads of address 1 never reload that shadow.
- R5: A read of word address 4 (the live trigger word) loads the shadows of addresses 2 and 3 from their status inputs. Reads of 2 and 3 return those shadows, and later changes on the status inputs are ignored until the next address-4 read.
- R6: A read of word address 4 returns the live value of its status input.
- R7: In every cycle in which ext_trig equals TRIG_ACT_HIGH, the shadows of addresses 5 and 6 load from their status inputs. At the other level they hold their value.
- R8: rd_acc bit 0 (wide counter) is high in the cycle of an address-0 read. Bits 1, 2 and 3 (addresses 2, 3 and 4) are high in the cycle of an address-4 read. Bits 4 and 5 (addresses 5 and 6) are high in each cycle the external trigger is active. Reads of addresses 1, 2, 3, 5, 6 and out-of-range addresses raise no bit.
- R9: A read of any word address above 6 is acknowledged with rd_data equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| rd_stb | input | 1 | Read request, one cycle |
| rd_addr | input | ADDR_W | Word address of the read |
| ext_trig | input | 1 | External capture trigger, polarity set by TRIG_ACT_HIGH |
| sts_b | input | DATA_W | Live status, shadowed at address 2 |
| sts_c | input | DATA_W | Live status, shadowed at address 3 |
| sts_d | input | DATA_W | Live status at address 4, the group trigger |
| sts_e | input | DATA_W | Live status, shadowed at address 5 |
| sts_f | input | DATA_W | Live status, shadowed at address 6 |
| rd_ack | output | 1 | Read acknowledge, one cycle after rd_stb |
| rd_data | output | DATA_W | Read data, valid with rd_ack |
| rd_acc | output | 6 | Per-register sampling strobes |

## Verification
Read data and acknowledge are due one clock after the strobe. The bench therefore drives each request on a falling edge, lets the rising edge register it, and compares rd_data on the following falling edge. The expected value is taken at the falling edge where the request is driven: the bench's own counter model and the status inputs in force then. Shadow loads happen on the same rising edge as the strobe or trigger, so the model updates its shadows at that edge. rd_acc is combinational and is checked one nanosecond after the request or trigger is driven, inside the same cycle.

// File: rtl/snap_pkg.sv
package snap_pkg;

  // One rd_acc bit per register in the group
  typedef enum logic [2:0] {
    REG_WIDE = 3'd0,
    REG_GRPB = 3'd1,
    REG_GRPC = 3'd2,
    REG_LIVE = 3'd3,
    REG_EXTE = 3'd4,
    REG_EXTF = 3'd5
  } reg_idx_e;

  localparam int unsigned NUM_REGS = 6;

  // Registers that follow the words of the wide counter
  localparam int unsigned NUM_NARROW = 5;

endpackage

// File: rtl/snap_wide_cnt.sv
module snap_wide_cnt #(
  parameter int unsigned         W       = 64,
  parameter logic [W-1:0]        RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt_q
);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/snap_shadow.sv
module snap_shadow #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  // The clock enable is written out as a hold mux
  always_comb begin
    q_nxt = q;
    if (ld) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/snap_decode.sv
module snap_decode
  import snap_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned WORDS  = 2
) (
  input  logic                rd_stb,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic                trig_act,
  output logic [WORDS-1:0]    wide_sel,
  output logic [NUM_NARROW-1:0] nar_sel,
  output logic                ld_wide,
  output logic                ld_grp,
  output logic                ld_ext,
  output logic [NUM_REGS-1:0] acc
);

  localparam logic [ADDR_W-1:0] NAR_BASE = ADDR_W'(WORDS);
  localparam int unsigned       LIVE_OFS = 2;

  always_comb begin
    wide_sel = '0;
    nar_sel  = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (rd_stb && (rd_addr == ADDR_W'(w))) begin
        wide_sel[w] = 1'b1;
      end
    end
    for (int n = 0; n < NUM_NARROW; n++) begin
      if (rd_stb && (rd_addr == NAR_BASE + ADDR_W'(n))) begin
        nar_sel[n] = 1'b1;
      end
    end
  end

  always_comb begin
    // Low word of the wide counter triggers itself
    ld_wide = wide_sel[0];
    // Reading the live word triggers the group pair
    ld_grp  = nar_sel[LIVE_OFS];
    ld_ext  = trig_act;
    acc           = '0;
    acc[REG_WIDE] = ld_wide;
    acc[REG_GRPB] = ld_grp;
    acc[REG_GRPC] = ld_grp;
    acc[REG_LIVE] = ld_grp;
    acc[REG_EXTE] = ld_ext;
    acc[REG_EXTF] = ld_ext;
  end

endmodule

// File: rtl/snap_rdbuf.sv
module snap_rdbuf
  import snap_pkg::*;
#(
  parameter int unsigned          DATA_W        = 32,
  parameter int unsigned          WIDE_W        = 64,
  parameter int unsigned          ADDR_W        = 4,
  parameter logic [WIDE_W-1:0]    CNT_RST       = '0,
  parameter logic                 TRIG_ACT_HIGH = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_stb,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic                ext_trig,
  input  logic [DATA_W-1:0]   sts_b,
  input  logic [DATA_W-1:0]   sts_c,
  input  logic [DATA_W-1:0]   sts_d,
  input  logic [DATA_W-1:0]   sts_e,
  input  logic [DATA_W-1:0]   sts_f,
  output logic                rd_ack,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_REGS-1:0] rd_acc
);

  localparam int unsigned WORDS = WIDE_W / DATA_W;

  logic [WIDE_W-1:0]        cnt_q;
  logic [DATA_W-1:0]        wide_view [WORDS];
  logic [WORDS-1:0]         wide_sel;
  logic [NUM_NARROW-1:0]    nar_sel;
  logic                     ld_wide;
  logic                     ld_grp;
  logic                     ld_ext;
  logic                     trig_act;
  logic [DATA_W-1:0]        shd_b;
  logic [DATA_W-1:0]        shd_c;
  logic [DATA_W-1:0]        shd_e;
  logic [DATA_W-1:0]        shd_f;
  logic [DATA_W-1:0]        nar_view [NUM_NARROW];
  logic [DATA_W-1:0]        rd_data_nxt;
  logic                     rd_ack_nxt;

  assign trig_act = (ext_trig == TRIG_ACT_HIGH);

  snap_wide_cnt #(
    .W       (WIDE_W),
    .RST_VAL (CNT_RST)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_q (cnt_q)
  );

  snap_decode #(
    .ADDR_W (ADDR_W),
    .WORDS  (WORDS)
  ) u_dec (
    .rd_stb   (rd_stb),
    .rd_addr  (rd_addr),
    .trig_act (trig_act),
    .wide_sel (wide_sel),
    .nar_sel  (nar_sel),
    .ld_wide  (ld_wide),
    .ld_grp   (ld_grp),
    .ld_ext   (ld_ext),
    .acc      (rd_acc)
  );

  // Word 0 bypasses its buffer: the live low word is returned
  assign wide_view[0] = cnt_q[DATA_W-1:0];

  // Upper words are captured on the same edge as the word-0 read
  for (genvar gw = 1; gw < WORDS; gw++) begin : g_wide_shd
    snap_shadow #(.W(DATA_W)) u_shd (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ld_wide),
      .d     (cnt_q[gw*DATA_W +: DATA_W]),
      .q     (wide_view[gw])
    );
  end

  snap_shadow #(.W(DATA_W)) u_shd_b (
    .clk (clk), .rst_n (rst_n), .ld (ld_grp), .d (sts_b), .q (shd_b)
  );
  snap_shadow #(.W(DATA_W)) u_shd_c (
    .clk (clk), .rst_n (rst_n), .ld (ld_grp), .d (sts_c), .q (shd_c)
  );
  snap_shadow #(.W(DATA_W)) u_shd_e (
    .clk (clk), .rst_n (rst_n), .ld (ld_ext), .d (sts_e), .q (shd_e)
  );
  snap_shadow #(.W(DATA_W)) u_shd_f (
    .clk (clk), .rst_n (rst_n), .ld (ld_ext), .d (sts_f), .q (shd_f)
  );

  assign nar_view[0] = shd_b;
  assign nar_view[1] = shd_c;
  assign nar_view[2] = sts_d;
  assign nar_view[3] = shd_e;
  assign nar_view[4] = shd_f;

  // Read mux: selects are one-hot, so an OR tree suffices
  always_comb begin
    rd_data_nxt = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (wide_sel[w]) begin
        rd_data_nxt = rd_data_nxt | wide_view[w];
      end
    end
    for (int n = 0; n < NUM_NARROW; n++) begin
      if (nar_sel[n]) begin
        rd_data_nxt = rd_data_nxt | nar_view[n];
      end
    end
    rd_ack_nxt = rd_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_ack  <= rd_ack_nxt;
      rd_data <= rd_data_nxt;
    end
  end

endmodule

// File: rtl/snap_rdbuf_chk.sv
module snap_rdbuf_chk #(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned WIDE_W        = 64,
  parameter int unsigned ADDR_W        = 4,
  parameter logic        TRIG_ACT_HIGH = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_stb,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              ext_trig,
  input logic              rd_ack,
  input logic [DATA_W-1:0] rd_data,
  input logic [5:0]        rd_acc,
  input logic [WIDE_W-1:0] cnt,
  input logic [DATA_W-1:0] wide_hi,
  input logic [DATA_W-1:0] shd_b,
  input logic [DATA_W-1:0] shd_e,
  input logic [DATA_W-1:0] sts_e
);

  localparam int unsigned       WORDS    = WIDE_W / DATA_W;
  localparam logic [ADDR_W-1:0] LIVE_ADR = ADDR_W'(WORDS + 2);
  localparam logic [ADDR_W-1:0] LAST_ADR = ADDR_W'(WORDS + 4);

  // Armed one edge after reset release, so $past never sees reset values
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
    end
  end

  assert_ack_next_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    rd_stb |=> rd_ack);

  assert_no_ack_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !rd_stb |=> !rd_ack);

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    cnt == $past(cnt) + WIDE_W'(1));

  assert_lo_live_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rd_stb && rd_addr == '0) |=> rd_data == $past(cnt[DATA_W-1:0]));

  assert_hi_coherent_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rd_stb && rd_addr == '0) |=> wide_hi == $past(cnt[2*DATA_W-1:DATA_W]));

  assert_grp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !(rd_stb && rd_addr == LIVE_ADR) |=> $stable(shd_b));

  assert_ext_load_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (ext_trig == TRIG_ACT_HIGH) |=> shd_e == $past(sts_e));

  assert_ext_hold_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (ext_trig != TRIG_ACT_HIGH) |=> $stable(shd_e));

  assert_acc_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rd_stb && rd_addr != '0 && rd_addr != LIVE_ADR && ext_trig != TRIG_ACT_HIGH)
      |-> rd_acc == 6'b0);

  assert_oor_zero_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rd_stb && rd_addr > LAST_ADR) |=> rd_data == '0);

endmodule

bind snap_rdbuf snap_rdbuf_chk #(
  .DATA_W        (DATA_W),
  .WIDE_W        (WIDE_W),
  .ADDR_W        (ADDR_W),
  .TRIG_ACT_HIGH (TRIG_ACT_HIGH)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_stb   (rd_stb),
  .rd_addr  (rd_addr),
  .ext_trig (ext_trig),
  .rd_ack   (rd_ack),
  .rd_data  (rd_data),
  .rd_acc   (rd_acc),
  .cnt      (cnt_q),
  .wide_hi  (wide_view[1]),
  .shd_b    (shd_b),
  .shd_e    (shd_e),
  .sts_e    (sts_e)
);

// File: tb/snap_rdbuf_tb.sv
`timescale 1ns/1ps
module snap_rdbuf_tb;

  localparam logic [63:0] CNT_RST = 64'h0000_0000_FFFF_FF00;

  logic        clk;
  logic        rst_n;
  logic        rd_stb;
  logic [3:0]  rd_addr;
  logic        ext_trig;
  logic [31:0] sts_b, sts_c, sts_d, sts_e, sts_f;
  logic        rd_ack;
  logic [31:0] rd_data;
  logic [5:0]  rd_acc;

  int total = 0;
  int bad   = 0;

  // Bench model state
  logic [63:0] mcnt;
  logic [31:0] m_hi, m_b, m_c, m_e, m_f;

  snap_rdbuf #(
    .DATA_W (32), .WIDE_W (64), .ADDR_W (4),
    .CNT_RST (CNT_RST), .TRIG_ACT_HIGH (1'b1)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .rd_stb (rd_stb), .rd_addr (rd_addr),
    .ext_trig (ext_trig), .sts_b (sts_b), .sts_c (sts_c), .sts_d (sts_d),
    .sts_e (sts_e), .sts_f (sts_f), .rd_ack (rd_ack), .rd_data (rd_data),
    .rd_acc (rd_acc)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mcnt <= CNT_RST;
    else        mcnt <= mcnt + 64'd1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_data(input int a);
    case (a)
      0: return mcnt[31:0];
      1: return m_hi;
      2: return m_b;
      3: return m_c;
      4: return sts_d;
      5: return m_e;
      6: return m_f;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0: return "R3";
      1: return "R4";
      2, 3: return "R5";
      4: return "R6";
      5, 6: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic do_read(input int a);
    logic [31:0] exp;
    logic [5:0]  exp_acc;
    @(negedge clk);
    rd_stb  = 1'b1;
    rd_addr = 4'(a);
    exp     = exp_data(a);
    exp_acc = (a == 0) ? 6'b000001 : (a == 4) ? 6'b001110 : 6'b000000;
    #1;
    check("R8 rd_acc", {58'h0, rd_acc}, {58'h0, exp_acc});
    @(posedge clk);
    if (a == 0) m_hi = mcnt[63:32] - ((mcnt[31:0] == 32'h0) ? 32'd1 : 32'd0);
    if (a == 4) begin m_b = sts_b; m_c = sts_c; end
    @(negedge clk);
    rd_stb = 1'b0;
    check("R2 ack", {63'h0, rd_ack}, 64'h1);
    check(tag_of(a), {32'h0, rd_data}, {32'h0, exp});
    #1;
    check("R2 ack drop", {63'h0, rd_ack}, 64'h1);
    @(posedge clk);
    #1;
    check("R2 no ack", {63'h0, rd_ack}, 64'h0);
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    ext_trig = 1'b1;
    #1;
    check("R8 ext acc", {58'h0, rd_acc}, 64'h30);
    @(posedge clk);
    m_e = sts_e; m_f = sts_f;
    @(negedge clk);
    ext_trig = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; rd_stb = 1'b0; rd_addr = '0; ext_trig = 1'b0;
    sts_b = 32'h1111_1111; sts_c = 32'h2222_2222; sts_d = 32'h3333_3333;
    sts_e = 32'h4444_4444; sts_f = 32'h5555_5555;
    m_hi = '0; m_b = '0; m_c = '0; m_e = '0; m_f = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 ack", {63'h0, rd_ack}, 64'h0);
    check("R1 data", {32'h0, rd_data}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: shadows read zero before any trigger
    do_read(1); do_read(2); do_read(3); do_read(5); do_read(6);

    // R4: carry crosses bit 32 between the low and the high read
    while (mcnt[31:0] < 32'hFFFF_FFF0) @(negedge clk);
    do_read(0);
    repeat (20) @(negedge clk);
    check("R4 carry passed", {63'h0, mcnt[63:32] != m_hi}, 64'h1);
    do_read(1);
    do_read(1);

    // R5/R6: group captured on live read, later changes ignored
    sts_b = 32'hA5A5_0001; sts_c = 32'h5A5A_0002; sts_d = 32'hCAFE_0003;
    do_read(4);
    sts_b = 32'hDEAD_0004; sts_c = 32'hBEEF_0005;
    do_read(2); do_read(3);

    // R7: inactive level keeps old shadow, active level captures
    sts_e = 32'h0BAD_0006;
    repeat (3) @(negedge clk);
    do_read(5);
    pulse_trig();
    sts_e = 32'h7777_0007;
    do_read(5); do_read(6);

    // R9: out of range
    do_read(7); do_read(15);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 8);
      if (op < 5) begin
        do_read(int'($urandom % 16));
      end else if (op == 5) begin
        sts_b = $urandom; sts_c = $urandom; sts_d = $urandom;
        sts_e = $urandom; sts_f = $urandom;
      end else if (op == 6) begin
        pulse_trig();
      end else begin
        repeat (int'($urandom % 5)) @(negedge clk);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule